// File: doc/BRIEF.md
# Expansion Slot Address Decoder with Clock/Disk Bank Steering

This block sits on the expansion slot of an 8-bit microprocessor system. From the 16-bit address, the single read/write line and the two block selects that the host already produces, it forms every chip select that the expansion card needs:

- two peripheral adapter selects;
- a spare I/O select;
- a disk controller select;
- a real-time clock select;
- two ROM selects.

Every select is active low.

Inside the 32-byte I/O block, one 16-byte window is shared between the disk controller and the real-time clock. A one-bit bank register decides which of the two devices the window reaches. Software sets that register by writing data bit D0 to a small write-only range. After reset the register points at the disk, so the disk is reachable straight away. The clock is built for a bus with separate read and write strobes, so the block splits the host's single read/write line into two active-low strobes. Each strobe is qualified by the clock select.

The cartridge ROM region is divided at its midpoint boundary. The lower 8 KB goes to the disk ROM. The upper part goes to a resident firmware ROM.

Top module: `xslot_decode`

## Requirements
- R1: With `io_blk_n` low, addresses 0xFF50–0xFF53 drive `adp0_cs_n` low, 0xFF54–0xFF57 drive `adp1_cs_n` low, and 0xFF5C–0xFF5F drive `spare_cs_n` low.
- R2: After reset the bank bit is 0, and an access to 0xFF40–0xFF4F with `io_blk_n` low drives `disk_cs_n` low.
- R3: A cycle with `rw`=0 (write), `io_blk_n` low and an address in 0xFF58–0xFF5B loads `d0` into the bank bit at the next rising `clk` edge. A value of 1 selects the clock and 0 selects the disk.
- R4: While the bank bit is 1, an access to 0xFF40–0xFF4F drives `rtc_cs_n` low and leaves `disk_cs_n` high.
- R5: `rtc_rd_n` is low exactly when `rtc_cs_n` is low and `rw`=1. `rtc_wr_n` is low exactly when `rtc_cs_n` is low and `rw`=0.
- R6: With `cart_blk_n` low, addresses 0xC000–0xDFFF drive `drom_cs_n` low and 0xE000–0xFEFF drive `from_cs_n` low.
- R7: No select is low unless its enclosing block select is low and the address lies inside that block (0xFF40–0xFF5F for I/O, 0xC000–0xFEFF for ROM).
- R8: At most one of the seven chip selects is low at any time.
- R9: A read of 0xFF58–0xFF5B drives no select low and leaves the bank bit unchanged.
- R10: Writes to any address outside 0xFF58–0xFF5B, or writes with `io_blk_n` high, leave the bank bit unchanged.
- R11: Driving `rst_n` low clears the bank bit at once, without waiting for a clock edge. Release of reset is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the bank bit updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| rw | input | 1 | 1 = read, 0 = write |
| cart_blk_n | input | 1 | Active-low cartridge ROM block select from the host |
| io_blk_n | input | 1 | Active-low I/O block select from the host |
| d0 | input | 1 | CPU data bit 0, used for bank register writes |
| adp0_cs_n | output | 1 | First peripheral adapter select |
| adp1_cs_n | output | 1 | Second peripheral adapter select |
| spare_cs_n | output | 1 | Spare I/O select |
| disk_cs_n | output | 1 | Disk controller select (shared window, bank 0) |
| rtc_cs_n | output | 1 | Real-time clock select (shared window, bank 1) |
| rtc_rd_n | output | 1 | Clock read strobe |
| rtc_wr_n | output | 1 | Clock write strobe |
| drom_cs_n | output | 1 | Disk ROM select |
| from_cs_n | output | 1 | Resident firmware ROM select |

## Verification
The embedded properties are checked on every cycle, whatever the address:

- the chip selects stay mutually exclusive;
- the two clock strobes are never low together, and each follows the clock select and `rw`;
- nothing is selected while the block selects are high;
- a bank-range read selects nothing;
- the bank bit either takes the written D0 or holds.

The address map itself can only be shown by the bench's sweeps. These cover every address, under both bank settings and both bus directions, with the block selects both consistent and forced inactive. The same holds for the power-up default, the asynchronous clear, and the fact that stray writes leave the window's target alone.

// File: rtl/xslot_pkg.sv
package xslot_pkg;
  // Decoded hits inside the I/O block, active high
  typedef struct packed {
    logic shared_win;
    logic adp0;
    logic adp1;
    logic bank_wr;
    logic spare;
  } io_hits_t;

  // Order of the four 4-byte slots in the upper half of the I/O block
  localparam int SLOT_ADP0  = 0;
  localparam int SLOT_ADP1  = 1;
  localparam int SLOT_BANK  = 2;
  localparam int SLOT_SPARE = 3;
endpackage

// File: rtl/xslot_rst_sync.sv
module xslot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xslot_io_decode.sv
module xslot_io_decode
  import xslot_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IO_BASE   = 16'hFF40,
  parameter int          BLK_LOG2  = 5,
  parameter int          SLOT_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_blk_n,
  output io_hits_t          hits
);
  localparam int HALF_BIT = BLK_LOG2 - 1;
  localparam int NSLOT    = 1 << (HALF_BIT - SLOT_LOG2);
  localparam int SEL_W    = HALF_BIT - SLOT_LOG2;

  logic             in_blk;
  logic [NSLOT-1:0] slot_hit;

  assign in_blk = !io_blk_n && (addr[ADDR_W-1:BLK_LOG2] == IO_BASE[ADDR_W-1:BLK_LOG2]);

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign slot_hit[g] = in_blk && addr[HALF_BIT] &&
                           (addr[HALF_BIT-1:SLOT_LOG2] == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    hits.shared_win = in_blk && !addr[HALF_BIT];
    hits.adp0       = slot_hit[SLOT_ADP0];
    hits.adp1       = slot_hit[SLOT_ADP1];
    hits.bank_wr    = slot_hit[SLOT_BANK];
    hits.spare      = slot_hit[SLOT_SPARE];
  end

  // R7
  io_quiet_chk: assert final (!( io_blk_n && (hits != '0)));
endmodule

// File: rtl/xslot_rom_split.sv
module xslot_rom_split #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] ROM_LO   = 16'hC000,
  parameter logic [15:0] ROM_MID  = 16'hE000,
  parameter logic [15:0] ROM_LAST = 16'hFEFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cart_blk_n,
  output logic              lo_hit,
  output logic              hi_hit
);
  assign lo_hit = !cart_blk_n && (addr >= ROM_LO)  && (addr < ROM_MID);
  assign hi_hit = !cart_blk_n && (addr >= ROM_MID) && (addr <= ROM_LAST);

  // R6
  rom_excl_chk: assert final (!(lo_hit && hi_hit));
endmodule

// File: rtl/xslot_bank_reg.sv
module xslot_bank_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic d_in,
  output logic bank_q
);
  logic bank_d;

  always_comb begin
    bank_d = bank_q;
    if (wr_en) bank_d = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= bank_d;
  end

  // R3
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_q == $past(d_in)));

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/xslot_decode.sv
module xslot_decode
  import xslot_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] IO_BASE    = 16'hFF40,
  parameter logic [15:0] ROM_LO     = 16'hC000,
  parameter logic [15:0] ROM_MID    = 16'hE000,
  parameter logic [15:0] ROM_LAST   = 16'hFEFF,
  parameter int          RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              cart_blk_n,
  input  logic              io_blk_n,
  input  logic              d0,
  output logic              adp0_cs_n,
  output logic              adp1_cs_n,
  output logic              spare_cs_n,
  output logic              disk_cs_n,
  output logic              rtc_cs_n,
  output logic              rtc_rd_n,
  output logic              rtc_wr_n,
  output logic              drom_cs_n,
  output logic              from_cs_n
);
  logic     rst_sync_n;
  io_hits_t hits;
  logic     rom_lo, rom_hi;
  logic     bank_q;
  logic     bank_wr_en;
  logic     rtc_hit;

  xslot_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xslot_io_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_io (
    .addr(addr), .io_blk_n(io_blk_n), .hits(hits)
  );

  xslot_rom_split #(.ADDR_W(ADDR_W), .ROM_LO(ROM_LO), .ROM_MID(ROM_MID),
                    .ROM_LAST(ROM_LAST)) u_rom (
    .addr(addr), .cart_blk_n(cart_blk_n), .lo_hit(rom_lo), .hi_hit(rom_hi)
  );

  assign bank_wr_en = hits.bank_wr && !rw;

  xslot_bank_reg u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bank_wr_en), .d_in(d0), .bank_q(bank_q)
  );

  assign rtc_hit    = hits.shared_win && bank_q;
  assign adp0_cs_n  = !hits.adp0;
  assign adp1_cs_n  = !hits.adp1;
  assign spare_cs_n = !hits.spare;
  assign disk_cs_n  = !(hits.shared_win && !bank_q);
  assign rtc_cs_n   = !rtc_hit;
  assign rtc_rd_n   = rtc_cs_n | !rw;
  assign rtc_wr_n   = rtc_cs_n | rw;
  assign drom_cs_n  = !rom_lo;
  assign from_cs_n  = !rom_hi;

  // R8
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({~adp0_cs_n, ~adp1_cs_n, ~spare_cs_n, ~disk_cs_n, ~rtc_cs_n,
                ~drom_cs_n, ~from_cs_n}) <= 1);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!rtc_rd_n && !rtc_wr_n));

  // R5
  strobe_qual_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rtc_rd_n || !rtc_wr_n) |-> (!rtc_cs_n && (rtc_rd_n == !rw)));

  // R7
  blocks_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_blk_n && cart_blk_n) |->
      (adp0_cs_n && adp1_cs_n && spare_cs_n && disk_cs_n && rtc_cs_n &&
       drom_cs_n && from_cs_n));

  // R9
  bank_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hits.bank_wr && rw) |=> $stable(bank_q));
endmodule

// File: tb/sim_xslot_decode.sv
module sim_xslot_decode;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        rw, cart_blk_n, io_blk_n, d0;
  logic adp0_cs_n, adp1_cs_n, spare_cs_n, disk_cs_n, rtc_cs_n;
  logic rtc_rd_n, rtc_wr_n, drom_cs_n, from_cs_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xslot_decode u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .cart_blk_n(cart_blk_n),
    .io_blk_n(io_blk_n), .d0(d0), .adp0_cs_n(adp0_cs_n), .adp1_cs_n(adp1_cs_n),
    .spare_cs_n(spare_cs_n), .disk_cs_n(disk_cs_n), .rtc_cs_n(rtc_cs_n),
    .rtc_rd_n(rtc_rd_n), .rtc_wr_n(rtc_wr_n), .drom_cs_n(drom_cs_n),
    .from_cs_n(from_cs_n)
  );

  // Bit order: adp0 adp1 spare disk rtc rd wr drom from (active low)
  function automatic logic [8:0] model(input int a, input bit r, input bit cn,
                                       input bit ion, input bit bank);
    bit io_in, win, p0, p1, sp, dk, rt, dr, fr;
    int off;
    io_in = !ion && a >= 'hFF40 && a <= 'hFF5F;
    off   = a - 'hFF40;
    win   = io_in && off < 16;
    p0    = io_in && off >= 16 && off < 20;
    p1    = io_in && off >= 20 && off < 24;
    sp    = io_in && off >= 28;
    dk    = win && !bank;
    rt    = win && bank;
    dr    = !cn && a >= 'hC000 && a < 'hE000;
    fr    = !cn && a >= 'hE000 && a < 'hFF00;
    return ~{p0, p1, sp, dk, rt, rt && r, rt && !r, dr, fr};
  endfunction

  function automatic string tag(input int a);
    if (a >= 'hFF40 && a < 'hFF50) return "R2/R4/R5";
    if (a >= 'hFF58 && a < 'hFF5C) return "R9";
    if (a >= 'hFF50 && a < 'hFF60) return "R1";
    if (a >= 'hC000 && a < 'hFF00) return "R6";
    return "R7/R8";
  endfunction

  function automatic logic [8:0] outs();
    return {adp0_cs_n, adp1_cs_n, spare_cs_n, disk_cs_n, rtc_cs_n,
            rtc_rd_n, rtc_wr_n, drom_cs_n, from_cs_n};
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%b exp=%b", req, addr, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic v, input logic ion);
    @(negedge clk);
    addr = a; rw = 1'b0; io_blk_n = ion; cart_blk_n = 1'b1; d0 = v;
    @(negedge clk);
    rw = 1'b1; io_blk_n = 1'b1; addr = 16'h0000; d0 = 1'b0;
  endtask

  task automatic probe_win(input string req, input bit bank);
    @(negedge clk);
    addr = 16'hFF47; rw = 1'b1; io_blk_n = 1'b0; cart_blk_n = 1'b1;
    #1 check(req, outs(), model('hFF47, 1'b1, 1'b1, 1'b0, bank));
    io_blk_n = 1'b1;
  endtask

  task automatic sweep(input bit bank, input bit force_idle);
    for (int a = 0; a < 65536; a++) begin
      for (int r = 0; r < 2; r++) begin
        bit ion, cn;
        ion = force_idle ? 1'b1 : !(a >= 'hFF40 && a <= 'hFF5F);
        cn  = force_idle ? 1'b1 : !(a >= 'hC000 && a <= 'hFEFF);
        addr = 16'(a); rw = r[0]; io_blk_n = ion; cart_blk_n = cn; d0 = bank;
        #1 check(force_idle ? "R7" : tag(a), outs(), model(a, r[0], cn, ion, bank));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD*WATCHDOG);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 16'hFF40; rw = 1'b1; io_blk_n = 1'b0; cart_blk_n = 1'b1; d0 = 1'b1;
    #2 check("R2 reset", outs(), model('hFF40, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    probe_win("R2 post-reset", 1'b0);

    sweep(1'b0, 1'b0);                      // R1 R2 R6 R7 R8 R9 with disk bank
    sweep(1'b0, 1'b1);                      // R7 blocks idle

    bus_write(16'hFF5A, 1'b1, 1'b0);        // R3 set clock bank
    probe_win("R3 set", 1'b1);
    sweep(1'b1, 1'b0);                      // R4 R5 under clock bank

    // R9: read of bank range with d0=0 leaves clock bank
    @(negedge clk);
    addr = 16'hFF59; rw = 1'b1; io_blk_n = 1'b0; d0 = 1'b0;
    #1 check("R9 read", outs(), 9'h1FF);
    @(negedge clk);
    probe_win("R9 hold", 1'b1);

    // R10: stray writes
    bus_write(16'hFF50, 1'b0, 1'b0);
    probe_win("R10 other addr", 1'b1);
    bus_write(16'hFF5C, 1'b0, 1'b0);
    probe_win("R10 spare addr", 1'b1);
    bus_write(16'hFF58, 1'b0, 1'b1);
    probe_win("R10 io idle", 1'b1);

    bus_write(16'hFF5B, 1'b0, 1'b0);        // R3 back to disk
    probe_win("R3 clear", 1'b0);
    bus_write(16'hFF58, 1'b1, 1'b0);
    probe_win("R3 set again", 1'b1);

    // R11: asynchronous clear mid-cycle
    @(negedge clk);
    addr = 16'hFF4F; rw = 1'b0; io_blk_n = 1'b0; d0 = 1'b1;
    #2 rst_n = 1'b0;
    #1 check("R11 async", outs(), model('hFF4F, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    probe_win("R11 after", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule